// File: doc/BRIEF.md
# Backplane Interrupt Vector Acknowledge Controller

This block is the core-side end of a shared interrupt backplane. Peripheral boards pull a common active-low request line and, once acknowledged, pull three open-drain vector lines. Several boards may drive at once, so the bus carries the bitwise AND of every value driven. When no board drives the lines they float high and read as 7. The value 7 therefore means "no vector" and is never a valid priority, which leaves seven usable vector codes (0 to 6).

The controller resynchronises the request and vector lines with a two-flop synchroniser. While the host logic signals it is ready, it answers a pending request by pulling the acknowledge line low. It then waits for the bus to leave 7 and latches the resolved value, and raises the acknowledge again. It waits for the boards to float the bus back to 7 before it hands the vector to the host as a one-cycle strobe. A cycle counter guards both waiting phases. If either phase stalls, the controller drops back to idle and raises a one-cycle error strobe.

Top module: `irq_vec_ack_ctrl`

## Requirements
- R1: After reset, ack_n is 1, vec_valid and timeout_err are 0, and vec_out reads 7 (all ones).
- R2: From idle, ack_n goes low only when req_n is low and host_ready is high. It falls on the third rising clock edge after req_n is driven low, and it stays high for as long as host_ready is low.
- R3: If host_ready falls while ack_n is low and no vector has been seen, ack_n returns high on the next edge, and neither vec_valid nor timeout_err pulses.
- R4: While ack_n is low, a bus value of 7 counts as no vector: ack_n stays low and vec_out does not change.
- R5: A bus value other than 7 seen while ack_n is low is latched as the vector. The latched value is the bus value itself, which is the bitwise AND of everything driven. ack_n then rises.
- R6: vec_valid is high for exactly one cycle, with vec_out equal to the latched vector. It comes only after the bus has returned to 7, and never while the vector is still held on the bus.
- R7: If no vector appears within TIMEOUT_CYC cycles of ack_n falling, timeout_err pulses for one cycle, ack_n is 1, and no vec_valid is produced.
- R8: If the bus does not return to 7 within TIMEOUT_CYC cycles of the vector being latched, timeout_err pulses for one cycle, and releasing the bus later produces no vec_valid.
- R9: Activity on the vector lines while idle is ignored: no acknowledge and no vec_valid.
- R10: The vector lines pass through two synchroniser flops. ack_n rises on the third rising edge after a vector is driven, and vec_valid rises on the third rising edge after the bus is released to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Shared interrupt request, low = pending |
| host_ready | input | 1 | Host able to service an interrupt |
| vec_bus | input | 3 | Wired-AND vector lines, 7 = idle |
| ack_n | output | 1 | Acknowledge to the boards, low = acknowledged |
| vec_out | output | 3 | Latched vector |
| vec_valid | output | 1 | One-cycle strobe: vec_out holds a new vector |
| timeout_err | output | 1 | One-cycle strobe: a waiting phase timed out |

## Verification
The bench sweeps every pair of board priorities and drives their bitwise AND onto the bus. It then checks the acknowledge edges and the strobe on the exact edges the synchroniser depth predicts. A controller that skipped a synchroniser stage would move those edges one cycle early. A controller that strobed on capture instead of on release would show vec_valid while the vector is still held. Both timeouts are forced, the second followed by a late release, so a leftover strobe after an error would be caught. The bench also drops host_ready mid-wait, which would expose a controller that kept the acknowledge low or flagged the withdrawal as an error.

// File: rtl/irq_ack_pkg.sv
`timescale 1ns/1ps
package irq_ack_pkg;
    parameter int VEC_W = 3;
    localparam logic [VEC_W-1:0] VEC_IDLE = '1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_VEC = 2'd1,
        ST_WAIT_REL = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e       state;
        logic             ack_n;
        logic [VEC_W-1:0] vec;
        logic             valid;
        logic             err;
    } ctl_regs_t;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = d;
            end else begin : g_rest
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wait_timer.sv
`timescale 1ns/1ps
module wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                     cnt_d = '0;
        else if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/ack_fsm.sv
`timescale 1ns/1ps
module ack_fsm
    import irq_ack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s_n,
    input  logic             host_ready,
    input  logic [VEC_W-1:0] vec_s,
    input  logic             expired,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic             ack_n,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             timeout_err
);
    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.valid = 1'b0;
        regs_d.err   = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (!req_s_n && host_ready) begin
                    regs_d.state = ST_WAIT_VEC;
                    regs_d.ack_n = 1'b0;
                end
            end
            ST_WAIT_VEC: begin
                if (!host_ready) begin
                    regs_d.state = ST_IDLE;
                    regs_d.ack_n = 1'b1;
                end else if (vec_s != VEC_IDLE) begin
                    regs_d.state = ST_WAIT_REL;
                    regs_d.ack_n = 1'b1;
                    regs_d.vec   = vec_s;
                end else if (expired) begin
                    regs_d.state = ST_IDLE;
                    regs_d.ack_n = 1'b1;
                    regs_d.err   = 1'b1;
                end
            end
            ST_WAIT_REL: begin
                if (vec_s == VEC_IDLE) begin
                    regs_d.state = ST_IDLE;
                    regs_d.valid = 1'b1;
                end else if (expired) begin
                    regs_d.state = ST_IDLE;
                    regs_d.err   = 1'b1;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
                regs_d.ack_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.ack_n <= 1'b1;
            regs_q.vec   <= VEC_IDLE;
            regs_q.valid <= 1'b0;
            regs_q.err   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tmr_run     = (regs_q.state != ST_IDLE);
    assign tmr_clear   = (regs_d.state != regs_q.state);
    assign ack_n       = regs_q.ack_n;
    assign vec_out     = regs_q.vec;
    assign vec_valid   = regs_q.valid;
    assign timeout_err = regs_q.err;
endmodule

// File: rtl/irq_vec_ack_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             host_ready,
    input  logic [VEC_W-1:0] vec_bus,
    output logic             ack_n,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             timeout_err
);
    logic [VEC_W:0] raw_in, sync_out;
    logic           req_s_n;
    logic [VEC_W-1:0] vec_s;
    logic           expired, tmr_clear, tmr_run;

    assign raw_in  = {req_n, vec_bus};
    assign req_s_n = sync_out[VEC_W];
    assign vec_s   = sync_out[VEC_W-1:0];

    bit_sync #(
        .WIDTH  (VEC_W + 1),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    wait_timer #(
        .LIMIT(TIMEOUT_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .expired(expired)
    );

    ack_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s_n    (req_s_n),
        .host_ready (host_ready),
        .vec_s      (vec_s),
        .expired    (expired),
        .tmr_clear  (tmr_clear),
        .tmr_run    (tmr_run),
        .ack_n      (ack_n),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid),
        .timeout_err(timeout_err)
    );
endmodule

// File: rtl/irq_ack_checker.sv
`timescale 1ns/1ps
module irq_ack_checker
    import irq_ack_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_ready,
    input logic             ack_n,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_valid,
    input logic             timeout_err
);
    assert_ack_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(host_ready));

    assert_vec_held_while_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |-> $stable(vec_out));

    assert_valid_not_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out != VEC_IDLE));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_valid_ack_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (ack_n && !timeout_err));

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    assert_err_ack_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> ack_n);
endmodule

bind irq_vec_ack_ctrl irq_ack_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .ack_n      (ack_n),
    .vec_out    (vec_out),
    .vec_valid  (vec_valid),
    .timeout_err(timeout_err)
);

// File: tb/sim_irq_vec_ack_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ack_ctrl;
    localparam int LIMIT = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       host_ready = 1'b1;
    logic [2:0] vec_bus = 3'b111;
    logic       ack_n;
    logic [2:0] vec_out;
    logic       vec_valid;
    logic       timeout_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_vec_ack_ctrl #(.SYNC_STAGES(2), .TIMEOUT_CYC(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .host_ready(host_ready),
        .vec_bus(vec_bus), .ack_n(ack_n), .vec_out(vec_out),
        .vec_valid(vec_valid), .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Step n cycles, noting any strobe seen.
    task automatic watch(input int n, output bit saw_v, output bit saw_e);
        saw_v = 0;
        saw_e = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (vec_valid)   saw_v = 1;
            if (timeout_err) saw_e = 1;
        end
    endtask

    task automatic txn(input logic [2:0] pa, input logic [2:0] pb);
        logic [2:0] exp_v;
        exp_v = pa & pb;
        @(negedge clk);
        req_n = 1'b0;
        tick(2);
        chk(ack_n == 1'b1, "R2 ack early", ack_n, 1);
        tick(1);
        chk(ack_n == 1'b0, "R2 ack third edge", ack_n, 0);
        tick(2);
        chk(ack_n == 1'b0 && !vec_valid, "R4 idle bus keeps ack", ack_n, 0);
        @(negedge clk);
        vec_bus = exp_v;
        req_n   = 1'b1;
        tick(2);
        chk(ack_n == 1'b0, "R10 ack before sync", ack_n, 0);
        tick(1);
        chk(ack_n == 1'b1, "R5 ack raised", ack_n, 1);
        tick(2);
        chk(!vec_valid, "R6 no strobe while held", vec_valid, 0);
        @(negedge clk);
        vec_bus = 3'b111;
        tick(2);
        chk(!vec_valid, "R10 strobe early", vec_valid, 0);
        tick(1);
        chk(vec_valid == 1'b1, "R6 strobe on release", vec_valid, 1);
        chk(vec_out == exp_v, "R5 latched vector", vec_out, exp_v);
        tick(1);
        chk(!vec_valid, "R6 single cycle", vec_valid, 0);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit sv, se;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(ack_n == 1'b1, "R1 ack_n", ack_n, 1);
        chk(!vec_valid, "R1 vec_valid", vec_valid, 0);
        chk(!timeout_err, "R1 timeout_err", timeout_err, 0);
        chk(vec_out == 3'd7, "R1 vec_out", vec_out, 7);

        // R9 bus activity while idle
        @(negedge clk);
        vec_bus = 3'd2;
        watch(10, sv, se);
        chk(ack_n == 1'b1, "R9 no ack", ack_n, 1);
        chk(!sv, "R9 no strobe", sv, 0);
        @(negedge clk);
        vec_bus = 3'd7;
        watch(6, sv, se);
        chk(!sv && !se, "R9 no strobe after", sv, 0);

        // R2 request with host not ready
        @(negedge clk);
        host_ready = 1'b0;
        req_n      = 1'b0;
        tick(10);
        chk(ack_n == 1'b1, "R2 held off by ready", ack_n, 1);
        @(negedge clk);
        host_ready = 1'b1;
        tick(1);
        chk(ack_n == 1'b0, "R2 ack after ready", ack_n, 0);

        // R3 ready withdrawn during vector wait
        @(negedge clk);
        req_n      = 1'b1;
        host_ready = 1'b0;
        tick(1);
        chk(ack_n == 1'b1, "R3 ack withdrawn", ack_n, 1);
        watch(8, sv, se);
        chk(!sv && !se, "R3 no strobes", se, 0);
        @(negedge clk);
        host_ready = 1'b1;
        tick(4);

        // R5 R6 sweep over all priority pairs (wired-AND)
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if ((a & b) != 7) txn(3'(a), 3'(b));
            end
        end

        // R7 vector never appears
        @(negedge clk);
        req_n = 1'b0;
        tick(3);
        chk(ack_n == 1'b0, "R7 acked", ack_n, 0);
        @(negedge clk);
        req_n = 1'b1;
        watch(2 * LIMIT, sv, se);
        chk(se, "R7 timeout strobe", se, 1);
        chk(!sv, "R7 no valid", sv, 0);
        chk(ack_n == 1'b1, "R7 ack released", ack_n, 1);

        // R8 vector never released
        @(negedge clk);
        req_n = 1'b0;
        tick(3);
        @(negedge clk);
        vec_bus = 3'd4;
        req_n   = 1'b1;
        tick(3);
        chk(ack_n == 1'b1, "R8 vector latched", ack_n, 1);
        watch(2 * LIMIT, sv, se);
        chk(se, "R8 timeout strobe", se, 1);
        chk(!sv, "R8 no valid while stuck", sv, 0);
        @(negedge clk);
        vec_bus = 3'd7;
        watch(8, sv, se);
        chk(!sv, "R8 no valid after late release", sv, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule